// File: doc/BRIEF.md
# Three-Bit Sliding Majority Detector

This block watches a serial stream that delivers at most one bit per clock, qualified by a valid strobe. On every valid cycle it raises its detect output when two or three of the last three bits are 1, where the bit arriving in that cycle is one of the three. Because the current bit takes part, detect answers in the same cycle the bit is presented. It is a Mealy machine of four states.

The state is the pair of the two bits received before the current one. An eight-entry table, indexed by that pair and the incoming bit, supplies the next pair and the detect value. A two-bit register holds the pair. Cycles without a valid bit leave the history untouched, so gaps in the stream do not disturb the window. Reset clears the history, which means bits from before reset count as zeros.

Top module: `maj3_stream_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the history to two zero bits. A single 1 presented just after reset therefore gives detect 0.
- R2: On a valid cycle, detect is 1 exactly when at least two of {second-previous bit, previous bit, current bit_in} are 1. The result appears combinationally in the same cycle as bit_in.
- R3: At each rising edge with bit_vld high, the history shifts by one place. The previous bit becomes the second-previous bit, bit_in becomes the previous bit, and the oldest bit leaves the window.
- R4: At a rising edge with bit_vld low, the history is held whatever the value of bit_in. The window then continues after the gap as though there had been no gap.
- R5: While bit_vld is low, detect is 0.
- R6: After reset, the valid bit sequence 0100110010001110010100 yields the detect sequence 0000011000000111000100.
- R7: Each of the eight combinations of the two-bit history and the current bit gives the majority value of those three bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| detect | output | 1 | High when the window holds two or more ones (valid cycles only) |

## Verification
The block has no parameters, so the bench builds its single configuration. A fixed three-bit window with an eight-entry table means that every table entry can be reached directly. Each entry is loaded by a reset followed by two bits, and then probed with the third bit. Beyond that, the bench plays the reference stream, checks that ones age out of the window, and places strobe gaps both where an ungated output would show and where a history that shifted during the gap would change the next result.

// File: rtl/maj3_stream_fsm.sv
module maj3_stream_fsm (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic detect
);

  function automatic logic [23:0] build_tbl();
    logic [23:0] t;
    t = '0;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] k;
      k = 3'(i);
      t[3*i +: 3] = {k[1], k[0], (k[2] & k[1]) | (k[2] & k[0]) | (k[1] & k[0])};
    end
    return t;
  endfunction

  localparam logic [23:0] STEP_TBL = build_tbl();

  logic [1:0] hist;
  logic [2:0] idx;
  logic [2:0] entry;

  assign idx    = {hist, bit_in};
  assign entry  = STEP_TBL[3*int'(idx) +: 3];
  assign detect = bit_vld & entry[0];

  always_ff @(posedge clk) begin
    if (rst)          hist <= 2'b00;
    else if (bit_vld) hist <= entry[2:1];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> hist == 2'b00); // R1
  AST_PAIR_FIRES: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && hist == 2'b11) |-> detect); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> hist[0] == $past(bit_in)); // R3
  AST_HOLD_GAP: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(hist)); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !detect); // R5

endmodule

// File: tb/tb_maj3_stream_fsm.sv
module tb_maj3_stream_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic detect;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  maj3_stream_fsm dut (.clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .detect(detect));

  always #4 clk = ~clk;

  task automatic check(input logic exp, input string tag);
    checks++;
    if (detect !== exp) begin
      errors++;
      $display("FAIL %s: detect=%b expected=%b", tag, detect, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic b, input logic exp, input string tag);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    #1 check(exp, tag);
  endtask

  task automatic idle(input logic b, input string tag);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b0;
    #1 check(1'b0, tag);
  endtask

  task automatic test_reset();
    do_reset();
    idle(1'b1, "R1 idle after reset");
    send(1'b1, 1'b0, "R1 single one after reset");
    send(1'b1, 1'b1, "R2 two ones");
    do_reset();
    send(1'b1, 1'b0, "R1 reset mid-stream clears history");
  endtask

  task automatic test_example();
    string si = "0100110010001110010100";
    string so = "0000011000000111000100";
    do_reset();
    for (int i = 0; i < si.len(); i++)
      send(si[i] == "1", so[i] == "1", "R6 reference stream");
  endtask

  task automatic test_all_entries();
    for (int h = 0; h < 4; h++) begin
      for (int x = 0; x < 2; x++) begin
        logic a, b, c;
        a = h[1]; b = h[0]; c = x[0];
        do_reset();
        send(a, 1'b0, "R7 load older");
        send(b, a & b, "R7 load newer");
        send(c, (a & b) | (a & c) | (b & c), "R7 table entry");
      end
    end
  endtask

  task automatic test_shift();
    do_reset();
    send(1'b1, 1'b0, "R3 shift 1");
    send(1'b1, 1'b1, "R3 shift 2");
    send(1'b0, 1'b1, "R3 shift 3");
    send(1'b0, 1'b0, "R3 one aged");
    send(1'b1, 1'b0, "R3 both aged out");
  endtask

  task automatic test_gap();
    do_reset();
    send(1'b1, 1'b0, "R4 first one");
    idle(1'b1, "R5 gap with one on input");
    idle(1'b1, "R5 gap with one on input");
    idle(1'b0, "R4 gap with zero on input");
    idle(1'b0, "R4 gap with zero on input");
    send(1'b1, 1'b1, "R4 history held over gap");
    idle(1'b0, "R5 idle after detect");
    send(1'b0, 1'b1, "R4 held pair of ones");
  endtask

  initial begin
    test_reset();
    test_example();
    test_all_entries();
    test_shift();
    test_gap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule